// File: doc/BRIEF.md
# DMA Linked-List Descriptor Fetcher

This block drives one DMA channel through a chain of block descriptors kept in memory. On a start pulse it takes an initial pointer and reads the descriptor at that address one 32-bit word at a time over a single-request memory port. Each word goes into its own channel register: source address, destination address, next pointer, lower control word and upper control word. When the last of these five words has arrived, the block raises a one-cycle load-valid pulse, and the channel may then move the data.

When the channel signals that its block is finished, the fetcher writes the upper control word back into the same descriptor with its done bit set. If a parameter is enabled, it also writes the channel's source and destination status words. It then follows the stored next pointer. The chain stops when the lower control word allows no further chaining or when the pointer's address part is zero. A sticky chain-done flag reports the end. The two low bits of every pointer are not part of the address: they select the bus master used for the fetch and are driven out beside the word-aligned address.

Top module: `dlf_fetcher`

## Requirements
- R1: After reset, `mem_req_o`, `load_valid_o` and `chain_done_o` are 0 and every loaded register output is 0.
- R2: A start pulse with a pointer whose bits 31:2 are nonzero issues exactly five reads, at addresses `P & ~3`, +4, +8, +12 and +16 in that order. During these reads `mem_master_o` equals `P[1:0]`.
- R3: The five words read land in order in `src_addr_o` (offset 0), `dst_addr_o` (+4), `next_ptr_o` (+8), `ctl_lo_o` (+12) and `ctl_hi_o` (+16). `load_valid_o` is high for exactly one cycle, in the cycle after the fifth read is acknowledged.
- R4: After `blk_done_i`, the block writes the upper control word with bit 12 forced to 1 to descriptor offset +16. With `WB_STATUS=0` (the default) this is the only write. With `WB_STATUS=1`, `src_stat_i` is then written to +20 and `dst_stat_i` to +24.
- R5: After the write-back, if bit 27 or bit 28 of `ctl_lo_o` is set and bits 31:2 of `next_ptr_o` are nonzero, the next descriptor is read at `next_ptr_o & ~3`, with `mem_master_o = next_ptr_o[1:0]`.
- R6: If bits 27 and 28 of `ctl_lo_o` are both 0, the chain ends after the write-back: `chain_done_o` goes to 1 and no further request is issued.
- R7: If bits 31:2 of the next pointer are all zero, the chain ends after the write-back even when the chaining bits are set.
- R8: A start pulse that arrives while a chain is in progress has no effect on the access sequence.
- R9: An accepted start clears `chain_done_o`. A start in idle with a pointer whose bits 31:2 are zero sets `chain_done_o` and issues no request.
- R10: Each request keeps its address, direction and write data unchanged until `mem_ack_i` is seen.
- R11: `blk_done_i` is ignored unless a loaded block is waiting for it; a pulse during the fetch causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a new chain |
| start_ptr_i | input | 32 | Initial descriptor pointer (bits 1:0 pick the master) |
| blk_done_i | input | 1 | Channel finished the current block |
| src_stat_i | input | 32 | Source status word for optional write-back |
| dst_stat_i | input | 32 | Destination status word for optional write-back |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_master_o | output | 2 | Bus master select for this access |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid |
| mem_rdata_i | input | 32 | Read data |
| src_addr_o | output | 32 | Loaded source address |
| dst_addr_o | output | 32 | Loaded destination address |
| next_ptr_o | output | 32 | Loaded next pointer |
| ctl_lo_o | output | 32 | Loaded lower control word |
| ctl_hi_o | output | 32 | Loaded upper control word |
| load_valid_o | output | 1 | One-cycle pulse: descriptor loaded |
| chain_done_o | output | 1 | Sticky flag: chain finished |

## Verification
Assertions check on every cycle that a pending request stays unchanged until acknowledged and that `load_valid_o` never lasts more than one cycle. They also check that no request is made while `chain_done_o` is set, that a start during a chain leaves the fetch base untouched, and that a completion strobe during a read never turns the next access into a write. Only the bench scenarios can show the order of addresses and masters across a whole chain, the mapping of words to registers, the write-back value, and which of the two end conditions stops the walk. They also show that stray start or completion pulses leave the access log unchanged, under acknowledge latencies of zero to three cycles.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

    localparam int unsigned WORD_W       = 32;
    localparam int unsigned IDX_W        = 3;
    localparam int unsigned RD_WORDS     = 5;   // words loaded into registers
    localparam int unsigned CTL_HI_IDX   = 4;
    localparam int unsigned SRC_STAT_IDX = 5;
    localparam int unsigned DST_STAT_IDX = 6;
    localparam int unsigned DST_CHAIN_BIT = 27;
    localparam int unsigned SRC_CHAIN_BIT = 28;
    localparam int unsigned DONE_BIT      = 12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_HOLD,
        ST_WBACK
    } fsm_e;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] nxt;
        logic [WORD_W-1:0] ctl_lo;
        logic [WORD_W-1:0] ctl_hi;
    } desc_t;

    function automatic logic [WORD_W-1:0] ptr_base(input logic [WORD_W-1:0] p);
        return {p[WORD_W-1:2], 2'b00};
    endfunction

    function automatic logic [1:0] ptr_master(input logic [WORD_W-1:0] p);
        return p[1:0];
    endfunction

    function automatic logic ptr_is_null(input logic [WORD_W-1:0] p);
        return (p[WORD_W-1:2] == '0);
    endfunction

    function automatic logic chain_on(input logic [WORD_W-1:0] lo);
        return lo[DST_CHAIN_BIT] | lo[SRC_CHAIN_BIT];
    endfunction

    function automatic logic [WORD_W-1:0] mark_done(input logic [WORD_W-1:0] hi);
        logic [WORD_W-1:0] r;
        r = hi;
        r[DONE_BIT] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/dlf_desc_regs.sv
module dlf_desc_regs
    import dlf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en_i,
    input  logic [IDX_W-1:0]  cap_idx_i,
    input  logic [WORD_W-1:0] cap_data_i,
    output desc_t             desc_o
);

    for (genvar g = 0; g < RD_WORDS; g++) begin : g_slot
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (cap_en_i && (cap_idx_i == IDX_W'(g))) begin
                q <= cap_data_i;
            end
        end
    end

    assign desc_o.src    = g_slot[0].q;
    assign desc_o.dst    = g_slot[1].q;
    assign desc_o.nxt    = g_slot[2].q;
    assign desc_o.ctl_lo = g_slot[3].q;
    assign desc_o.ctl_hi = g_slot[4].q;

    // R3: only register-backed word positions are ever captured
    a_r3_capture_in_range: assert property (@(posedge clk) disable iff (rst)
        cap_en_i |-> (cap_idx_i < IDX_W'(RD_WORDS)));

endmodule

// File: rtl/dlf_ctrl.sv
module dlf_ctrl
    import dlf_pkg::*;
#(
    parameter bit WB_STATUS = 1'b0
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] start_ptr_i,
    input  logic              blk_done_i,
    input  logic              chain_en_i,
    input  logic [WORD_W-1:0] nxt_ptr_i,
    input  logic [WORD_W-1:0] ctl_hi_i,
    input  logic [WORD_W-1:0] src_stat_i,
    input  logic [WORD_W-1:0] dst_stat_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic [1:0]        mem_master_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    output logic              cap_en_o,
    output logic [IDX_W-1:0]  cap_idx_o,
    output logic              load_valid_o,
    output logic              chain_done_o
);

    localparam logic [IDX_W-1:0] RD_LAST  = IDX_W'(RD_WORDS - 1);
    localparam logic [IDX_W-1:0] WB_FIRST = IDX_W'(CTL_HI_IDX);
    localparam logic [IDX_W-1:0] WB_LAST  = WB_STATUS ? IDX_W'(DST_STAT_IDX)
                                                      : IDX_W'(CTL_HI_IDX);
    localparam logic [IDX_W-1:0] SRC_ST   = IDX_W'(SRC_STAT_IDX);
    localparam logic [IDX_W-1:0] DST_ST   = IDX_W'(DST_STAT_IDX);

    fsm_e              state_q;
    logic [WORD_W-1:0] base_q;
    logic [1:0]        mst_q;
    logic [IDX_W-1:0]  idx_q;
    logic              lv_q;
    logic              done_q;
    logic              follow_w;

    assign follow_w = chain_en_i && !ptr_is_null(nxt_ptr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            mst_q   <= '0;
            idx_q   <= '0;
            lv_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            lv_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (ptr_is_null(start_ptr_i)) begin
                            done_q <= 1'b1;
                        end else begin
                            done_q  <= 1'b0;
                            base_q  <= ptr_base(start_ptr_i);
                            mst_q   <= ptr_master(start_ptr_i);
                            idx_q   <= '0;
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_ack_i) begin
                        if (idx_q == RD_LAST) begin
                            lv_q    <= 1'b1;
                            state_q <= ST_HOLD;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (blk_done_i) begin
                        idx_q   <= WB_FIRST;
                        state_q <= ST_WBACK;
                    end
                end
                ST_WBACK: begin
                    if (mem_ack_i) begin
                        if (idx_q == WB_LAST) begin
                            if (follow_w) begin
                                base_q  <= ptr_base(nxt_ptr_i);
                                mst_q   <= ptr_master(nxt_ptr_i);
                                idx_q   <= '0;
                                state_q <= ST_FETCH;
                            end else begin
                                done_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (idx_q)
            SRC_ST:  mem_wdata_o = src_stat_i;
            DST_ST:  mem_wdata_o = dst_stat_i;
            default: mem_wdata_o = mark_done(ctl_hi_i);
        endcase
    end

    assign mem_req_o    = (state_q == ST_FETCH) || (state_q == ST_WBACK);
    assign mem_we_o     = (state_q == ST_WBACK);
    assign mem_addr_o   = base_q + {{(WORD_W-IDX_W-2){1'b0}}, idx_q, 2'b00};
    assign mem_master_o = mst_q;
    assign cap_en_o     = (state_q == ST_FETCH) && mem_ack_i;
    assign cap_idx_o    = idx_q;
    assign load_valid_o = lv_q;
    assign chain_done_o = done_q;

    // R3: load indication is a single-cycle pulse
    a_r3_load_pulse: assert property (@(posedge clk) disable iff (rst)
        load_valid_o |=> !load_valid_o);

    // R10: an unanswered request holds its address, direction and data
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R6: a finished chain issues no traffic
    a_r6_done_quiet: assert property (@(posedge clk) disable iff (rst)
        chain_done_o |-> !mem_req_o);

    // R8: a start during an active chain leaves the fetch base alone
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        ((state_q != ST_IDLE) && start_i && !((state_q == ST_WBACK) && mem_ack_i))
        |=> $stable(base_q));

    // R11: completion strobe during a read never produces a write next
    a_r11_done_during_read: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_we_o && blk_done_i) |=> !mem_we_o);

endmodule

// File: rtl/dlf_fetcher.sv
module dlf_fetcher
    import dlf_pkg::*;
#(
    parameter bit WB_STATUS = 1'b0
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [31:0] start_ptr_i,
    input  logic        blk_done_i,
    input  logic [31:0] src_stat_i,
    input  logic [31:0] dst_stat_i,
    output logic        mem_req_o,
    output logic        mem_we_o,
    output logic [31:0] mem_addr_o,
    output logic [1:0]  mem_master_o,
    output logic [31:0] mem_wdata_o,
    input  logic        mem_ack_i,
    input  logic [31:0] mem_rdata_i,
    output logic [31:0] src_addr_o,
    output logic [31:0] dst_addr_o,
    output logic [31:0] next_ptr_o,
    output logic [31:0] ctl_lo_o,
    output logic [31:0] ctl_hi_o,
    output logic        load_valid_o,
    output logic        chain_done_o
);

    desc_t             desc_w;
    logic              cap_en_w;
    logic [IDX_W-1:0]  cap_idx_w;

    dlf_ctrl #(.WB_STATUS(WB_STATUS)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_ptr_i  (start_ptr_i),
        .blk_done_i   (blk_done_i),
        .chain_en_i   (chain_on(desc_w.ctl_lo)),
        .nxt_ptr_i    (desc_w.nxt),
        .ctl_hi_i     (desc_w.ctl_hi),
        .src_stat_i   (src_stat_i),
        .dst_stat_i   (dst_stat_i),
        .mem_req_o    (mem_req_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_master_o (mem_master_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_ack_i    (mem_ack_i),
        .cap_en_o     (cap_en_w),
        .cap_idx_o    (cap_idx_w),
        .load_valid_o (load_valid_o),
        .chain_done_o (chain_done_o)
    );

    dlf_desc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .cap_en_i   (cap_en_w),
        .cap_idx_i  (cap_idx_w),
        .cap_data_i (mem_rdata_i),
        .desc_o     (desc_w)
    );

    assign src_addr_o = desc_w.src;
    assign dst_addr_o = desc_w.dst;
    assign next_ptr_o = desc_w.nxt;
    assign ctl_lo_o   = desc_w.ctl_lo;
    assign ctl_hi_o   = desc_w.ctl_hi;

endmodule

// File: tb/dlf_fetcher_tb_top.sv
`timescale 1ns/1ps
module dlf_fetcher_tb_top;

    typedef struct packed {
        logic [31:0] ptr;
        logic [1:0]  lat;
        logic [2:0]  nblk;
        logic        term;        // 1: end by null pointer, 0: end by chain bits
        logic        poke_start;
        logic        poke_done;
    } scen_t;

    localparam int NSCEN = 5;
    localparam scen_t SCEN [NSCEN] = '{
        '{32'h0000_0020, 2'd0, 3'd1, 1'b0, 1'b0, 1'b0},
        '{32'h0000_0041, 2'd1, 3'd3, 1'b0, 1'b0, 1'b0},
        '{32'h0000_000A, 2'd2, 3'd4, 1'b1, 1'b1, 1'b0},
        '{32'h0000_0063, 2'd3, 3'd2, 1'b0, 1'b0, 1'b1},
        '{32'h0000_0010, 2'd0, 3'd5, 1'b1, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_ptr = '0;
    logic        blk_done = 1'b0;
    logic        mem_req, mem_we, mem_ack, load_valid, chain_done;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_master;
    logic [31:0] src_addr, dst_addr, next_ptr, ctl_lo, ctl_hi;

    always #4 clk = ~clk;

    dlf_fetcher dut_i (
        .clk(clk), .rst(rst), .start_i(start), .start_ptr_i(start_ptr),
        .blk_done_i(blk_done), .src_stat_i(32'hAAAA_0001), .dst_stat_i(32'hBBBB_0002),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_master_o(mem_master), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
        .mem_rdata_i(mem_rdata), .src_addr_o(src_addr), .dst_addr_o(dst_addr),
        .next_ptr_o(next_ptr), .ctl_lo_o(ctl_lo), .ctl_hi_o(ctl_hi),
        .load_valid_o(load_valid), .chain_done_o(chain_done)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // memory model and access log (acts on the falling edge)
    logic [31:0] mem [64];
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    logic        log_we   [64];
    logic [1:0]  log_mst  [64];
    int          log_n = 0;
    int          hold_err = 0;
    int          lat_cur = 0;
    int          wait_cnt = 0;
    bit          pend = 1'b0;
    logic [31:0] pend_addr = '0;

    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
    end

    always @(negedge clk) begin
        if (rst || !mem_req) begin
            if (!rst && pend) hold_err++;
            mem_ack = 1'b0;
            wait_cnt = 0;
            pend = 1'b0;
        end else begin
            if (pend && (mem_addr != pend_addr)) hold_err++;
            if (wait_cnt >= lat_cur) begin
                mem_ack = 1'b1;
                mem_rdata = mem[mem_addr[7:2]];
                if (log_n < 64) begin
                    log_addr[log_n] = mem_addr;
                    log_data[log_n] = mem_wdata;
                    log_we[log_n]   = mem_we;
                    log_mst[log_n]  = mem_master;
                end
                log_n++;
                if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
                wait_cnt = 0;
                pend = 1'b0;
            end else begin
                mem_ack = 1'b0;
                wait_cnt++;
                pend = 1'b1;
                pend_addr = mem_addr;
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // expected descriptor contents, derived from the requirements
    function automatic logic [31:0] d_addr(scen_t s, int k);
        return {s.ptr[31:2], 2'b00} + 32'(k * 32);
    endfunction
    function automatic logic [1:0] d_mst(scen_t s, int k);
        return 2'(int'(s.ptr[1:0]) + k);
    endfunction
    function automatic logic [31:0] d_next(scen_t s, int k);
        if (k < int'(s.nblk) - 1) return d_addr(s, k + 1) | {30'd0, d_mst(s, k + 1)};
        return s.term ? 32'h0000_0003 : 32'h0000_00C4;
    endfunction
    function automatic logic [31:0] d_lo(scen_t s, int k);
        logic [31:0] v;
        v = 32'h0000_0011 | 32'(k << 8);
        if (k < int'(s.nblk) - 1) v = v | ((k % 2 == 1) ? 32'h1000_0000 : 32'h0800_0000);
        else if (s.term) v = v | 32'h1800_0000;
        return v;
    endfunction
    function automatic logic [31:0] d_hi(int k);
        return 32'h0000_0200 + 32'(k);
    endfunction
    function automatic logic [31:0] d_src(int si, int k);
        return 32'h1000_0000 + 32'(si * 256 + k);
    endfunction
    function automatic logic [31:0] d_dst(int si, int k);
        return 32'h2000_0000 + 32'(si * 256 + k);
    endfunction

    task automatic build(input int si);
        scen_t s;
        s = SCEN[si];
        for (int w = 0; w < 64; w++) mem[w] = '0;
        for (int k = 0; k < int'(s.nblk); k++) begin
            int i;
            i = int'(d_addr(s, k) >> 2);
            mem[i]     = d_src(si, k);
            mem[i + 1] = d_dst(si, k);
            mem[i + 2] = d_next(s, k);
            mem[i + 3] = d_lo(s, k);
            mem[i + 4] = d_hi(k);
            mem[i + 5] = 32'h5A5A_0000 + 32'(k);
            mem[i + 6] = 32'hA5A5_0000 + 32'(k);
        end
    endtask

    task automatic wait_load(output bit ok);
        ok = 1'b0;
        for (int c = 0; c < 200; c++) begin
            if (load_valid) begin
                ok = 1'b1;
                break;
            end
            tick();
        end
    endtask

    task automatic wait_log(input int target);
        for (int c = 0; c < 200; c++) begin
            if (log_n >= target) break;
            tick();
        end
    endtask

    task automatic run_scen(input int si);
        scen_t s;
        bit ok;
        s = SCEN[si];
        build(si);
        lat_cur = int'(s.lat);
        log_n = 0;
        start = 1'b1;
        start_ptr = s.ptr;
        tick();
        start = 1'b0;
        chk(chain_done == 1'b0, "R9 start clears chain_done", 32'(chain_done), 32'd0);
        if (s.poke_start) begin
            tick();
            start = 1'b1;
            start_ptr = 32'h0000_0080;
            tick();
            start = 1'b0;
        end
        if (s.poke_done) begin
            tick();
            blk_done = 1'b1;
            tick();
            blk_done = 1'b0;
        end
        for (int k = 0; k < int'(s.nblk); k++) begin
            wait_load(ok);
            chk(ok, "R3 load_valid seen", 32'(ok), 32'd1);
            chk(src_addr == d_src(si, k), "R3 src_addr", src_addr, d_src(si, k));
            chk(dst_addr == d_dst(si, k), "R3 dst_addr", dst_addr, d_dst(si, k));
            chk(next_ptr == d_next(s, k), "R3 next_ptr", next_ptr, d_next(s, k));
            chk(ctl_lo == d_lo(s, k), "R3 ctl_lo", ctl_lo, d_lo(s, k));
            chk(ctl_hi == d_hi(k), "R3 ctl_hi", ctl_hi, d_hi(k));
            tick();
            chk(load_valid == 1'b0, "R3 load_valid one cycle", 32'(load_valid), 32'd0);
            if (s.poke_done && k == 0) begin
                repeat (4) tick();
                chk(log_n == 5, "R11 early blk_done ignored (access count)", 32'(log_n), 32'd5);
            end
            blk_done = 1'b1;
            tick();
            blk_done = 1'b0;
            wait_log(6 * (k + 1));
        end
        repeat (4) tick();
        if (s.term) begin
            chk(chain_done == 1'b1, "R7 null next ends chain", 32'(chain_done), 32'd1);
            chk(log_n == 6 * int'(s.nblk), "R7 no access after null next", 32'(log_n), 32'(6 * int'(s.nblk)));
        end else begin
            chk(chain_done == 1'b1, "R6 clear chain bits end chain", 32'(chain_done), 32'd1);
            chk(log_n == 6 * int'(s.nblk), "R6 no access after last block", 32'(log_n), 32'(6 * int'(s.nblk)));
        end
        for (int k = 0; k < int'(s.nblk); k++) begin
            for (int j = 0; j < 5; j++) begin
                int e;
                logic [31:0] ea;
                e = 6 * k + j;
                ea = d_addr(s, k) + 32'(4 * j);
                if (k == 0) begin
                    chk(log_addr[e] == ea && !log_we[e], "R2 read order/address", log_addr[e], ea);
                    chk(log_mst[e] == d_mst(s, k), "R2 master select", 32'(log_mst[e]), 32'(d_mst(s, k)));
                end else begin
                    chk(log_addr[e] == ea && !log_we[e], "R5 next block read address", log_addr[e], ea);
                    chk(log_mst[e] == d_mst(s, k), "R5 next block master", 32'(log_mst[e]), 32'(d_mst(s, k)));
                end
            end
            chk(log_we[6 * k + 5] && log_addr[6 * k + 5] == d_addr(s, k) + 32'd16,
                "R4 write-back address", log_addr[6 * k + 5], d_addr(s, k) + 32'd16);
            chk(log_data[6 * k + 5] == (d_hi(k) | 32'h0000_1000),
                "R4 write-back done bit", log_data[6 * k + 5], d_hi(k) | 32'h0000_1000);
        end
        if (s.poke_start) chk(log_addr[0] != 32'h80 && log_n == 6 * int'(s.nblk),
                              "R8 start during chain ignored", 32'(log_n), 32'(6 * int'(s.nblk)));
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(mem_req == 1'b0, "R1 no request after reset", 32'(mem_req), 32'd0);
        chk(chain_done == 1'b0, "R1 chain_done after reset", 32'(chain_done), 32'd0);
        chk(load_valid == 1'b0, "R1 load_valid after reset", 32'(load_valid), 32'd0);
        chk((src_addr | dst_addr | next_ptr | ctl_lo | ctl_hi) == 32'd0,
            "R1 registers zero after reset", src_addr | dst_addr | next_ptr | ctl_lo | ctl_hi, 32'd0);
        // R9 null start pointer
        start = 1'b1;
        start_ptr = 32'h0000_0002;
        tick();
        start = 1'b0;
        chk(chain_done == 1'b1, "R9 null start sets chain_done", 32'(chain_done), 32'd1);
        repeat (4) tick();
        chk(log_n == 0 && !mem_req, "R9 null start issues no request", 32'(log_n), 32'd0);
        // R11 stray completion in idle
        blk_done = 1'b1;
        tick();
        blk_done = 1'b0;
        repeat (3) tick();
        chk(log_n == 0, "R11 blk_done in idle ignored", 32'(log_n), 32'd0);
        // table of chains
        for (int si = 0; si < NSCEN; si++) run_scen(si);
        chk(hold_err == 0, "R10 request held until ack", 32'(hold_err), 32'd0);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1..R11 run act=hung exp=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule